// File: doc/BRIEF.md
# Saturating Line Error Counter Bank with Snapshot Buffers

This block keeps five independent 16-bit counts of receive-side line errors: code violations, framing bit errors, CRC-6 errors, errored blocks and pseudo-random test pattern bit errors. Each error source delivers single-cycle pulses. The counts saturate and never wrap.

Software does not read the live counts. Each lane copies its live count into a buffer register. Software reads that buffer while the live counter starts a new period. The copy happens in one of two ways, chosen by `mode_auto_i`:

- In one-second mode, every `tick_i` pulse triggers the copy.
- In on-demand mode, a latch request triggers the copy through a one-cycle handshake. The `busy_o` flag stays high until the buffers hold the new snapshot.

An error pulse that coincides with a restart is never lost. It becomes the first count of the new period. The register decode that produces the latch request lies outside this block.

Top module: `err_cnt_bank`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every buffer field of `buf_o` reads 0 and `busy_o` is 0.
- R2: A high bit of `ev_i` at a clock edge raises only that lane's live count by one. Lanes never affect one another.
- R3: With `mode_auto_i` = 1, a clock edge with `tick_i` high loads each buffer with its lane's live count. The live count restarts for the next period. The new buffer value is visible right after that edge.
- R4: With `mode_auto_i` = 0, a clock edge with `latch_req_i` high sets `busy_o`. The next edge loads every buffer from its live count, restarts the counts and clears `busy_o`.
- R5: Buffers hold their value at every edge that performs no copy, whatever events arrive.
- R6: A live count that has reached 65535 stays at 65535 under further events until the next restart.
- R7: An event at the same edge as a restart is counted in the new period. After such a restart the lane's count is 1, not 0.
- R8: In one-second mode `latch_req_i` is ignored and `busy_o` stays 0. In on-demand mode `tick_i` is ignored and the buffers stay unchanged.
- R9: Lane order, used for both `ev_i` bit i and `buf_o` field i:
  - 0: code violations
  - 1: framing bit errors
  - 2: CRC-6 errors
  - 3: errored blocks
  - 4: test pattern bit errors

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_i | input | 5 | Error event pulses, one bit per lane |
| tick_i | input | 1 | One-second tick pulse |
| mode_auto_i | input | 1 | 1 = copy on tick, 0 = copy on request |
| latch_req_i | input | 1 | On-demand latch request pulse |
| buf_o | output | 5x16 | Buffered counts, field i belongs to lane i |
| busy_o | output | 1 | Handshake flag, high while a requested copy is pending |

## Verification
The bench aims an event at the exact edge where a restart happens. A design that cleared the count after incrementing would read 0 where 1 is due.

The bench also drives one lane far past 65535 events. A wrapping counter would then show a small residue instead of 65535.

Tick and request are each applied in the wrong mode. A design that honoured them would alter the buffers or raise `busy_o`.

Separate per-lane counts expose swapped or shared lanes. Checking `busy_o` one and two cycles after the request exposes an off-by-one handshake.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
    parameter int unsigned ERR_LANES = 5;
    parameter int unsigned ERR_WIDTH = 16;

    typedef enum int unsigned {
        LANE_CODE_VIOL = 0,
        LANE_FRAME_BIT = 1,
        LANE_CRC6      = 2,
        LANE_ERR_BLOCK = 3,
        LANE_PATTERN   = 4
    } err_lane_e;
endpackage

// File: rtl/err_latch_ctrl.sv
module err_latch_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic mode_auto_i,
    input  logic latch_req_i,
    output logic clr_o,
    output logic busy_o
);
    typedef struct packed {
        logic busy;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.busy = 1'b0;
        end else if (!mode_auto_i && latch_req_i) begin
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign clr_o  = (mode_auto_i && tick_i) || st_q.busy;
    assign busy_o = st_q.busy;

    // R4: handshake flag lasts exactly one cycle
    a_r4_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |=> !st_q.busy);
    // R4: a request in on-demand mode raises the flag
    a_r4_req_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (!mode_auto_i && latch_req_i && !st_q.busy) |=> st_q.busy);
    // R8: requests are ignored in one-second mode
    a_r8_req_ignored: assert property (@(posedge clk) disable iff (rst)
        (mode_auto_i && !st_q.busy) |=> !st_q.busy);
endmodule

// File: rtl/err_cnt_lane.sv
module err_cnt_lane #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] buf_o
);
    localparam logic [WIDTH-1:0] MAX_CNT = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE_CNT = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] snap;
    } lane_s;

    lane_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.snap = st_q.cnt;
            st_d.cnt  = ev_i ? ONE_CNT : '0;
        end else if (ev_i && st_q.cnt != MAX_CNT) begin
            st_d.cnt = st_q.cnt + ONE_CNT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign buf_o = st_q.snap;

    // R6: a saturated count stays saturated until restart
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == MAX_CNT && !clr_i) |=> st_q.cnt == MAX_CNT);
    // R2: an event below the limit advances the count by one
    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && ev_i && st_q.cnt != MAX_CNT) |=> st_q.cnt == $past(st_q.cnt) + ONE_CNT);
    // R7: an event coinciding with a restart starts the new period at one
    a_r7_restart_with_event: assert property (@(posedge clk) disable iff (rst)
        (clr_i && ev_i) |=> st_q.cnt == ONE_CNT);
    a_r7_restart_quiet: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !ev_i) |=> st_q.cnt == '0);
    // R3: a restart copies the live count to the buffer
    a_r3_copy: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> st_q.snap == $past(st_q.cnt));
    // R5: the buffer holds without a restart
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> $stable(st_q.snap));
endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank
    import err_cnt_pkg::*;
#(
    parameter int unsigned LANES = ERR_LANES,
    parameter int unsigned WIDTH = ERR_WIDTH
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            ev_i,
    input  logic                        tick_i,
    input  logic                        mode_auto_i,
    input  logic                        latch_req_i,
    output logic [LANES-1:0][WIDTH-1:0] buf_o,
    output logic                        busy_o
);
    logic clr;

    err_latch_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .mode_auto_i (mode_auto_i),
        .latch_req_i (latch_req_i),
        .clr_o       (clr),
        .busy_o      (busy_o)
    );

    // R9: lane i takes ev_i[i] and drives buf_o[i]
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        err_cnt_lane #(.WIDTH(WIDTH)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .ev_i  (ev_i[g]),
            .clr_i (clr),
            .buf_o (buf_o[g])
        );
    end

    // R8: a tick in on-demand mode with no pending request leaves buffers alone
    a_r8_tick_ignored: assert property (@(posedge clk) disable iff (rst)
        (!mode_auto_i && !busy_o) |=> $stable(buf_o));
endmodule

// File: tb/err_cnt_bank_tb.sv
module err_cnt_bank_tb;
    import err_cnt_pkg::*;

    localparam int N = 5;
    localparam int W = 16;
    localparam int MAXV = 65535;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] ev = '0;
    logic tick = 1'b0;
    logic mode_auto = 1'b1;
    logic req = 1'b0;
    logic [N-1:0][W-1:0] buf_o;
    logic busy;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt [N];
    int exp_buf [N];
    int cycles = 0;

    always #2.5 clk = ~clk;

    err_cnt_bank u_dut (
        .clk(clk), .rst(rst), .ev_i(ev), .tick_i(tick),
        .mode_auto_i(mode_auto), .latch_req_i(req),
        .buf_o(buf_o), .busy_o(busy)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req_tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req_tag, act, expv);
        end
    endtask

    task automatic chk_bufs(input string req_tag);
        for (int i = 0; i < N; i++) chk(req_tag, int'(buf_o[i]), exp_buf[i]);
    endtask

    // bench model of the live counts
    function automatic void model_events(input logic [N-1:0] m);
        for (int i = 0; i < N; i++)
            if (m[i] && exp_cnt[i] < MAXV) exp_cnt[i]++;
    endfunction

    function automatic void model_latch(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) begin
            exp_buf[i] = exp_cnt[i];
            exp_cnt[i] = m[i] ? 1 : 0;
        end
    endfunction

    task automatic pulse(input logic [N-1:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ev = m; model_events(m);
        end
        @(negedge clk); ev = '0;
    endtask

    task automatic do_tick(input logic [N-1:0] m);
        @(negedge clk); tick = 1'b1; ev = m;
        if (mode_auto) model_latch(m); else model_events(m);
        @(negedge clk); tick = 1'b0; ev = '0;
    endtask

    task automatic do_req(input logic [N-1:0] m, input string req_tag);
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        chk(req_tag, int'(busy), 1);
        ev = m; model_latch(m);
        @(negedge clk); ev = '0;
        chk(req_tag, int'(busy), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin exp_cnt[i] = 0; exp_buf[i] = 0; end
        chk_bufs("R1");
        chk("R1", int'(busy), 0);
    endtask

    task automatic t_auto_tick();
        mode_auto = 1'b1;
        for (int i = 0; i < N; i++) pulse(N'(1) << i, i + 1);
        do_tick('0);
        // R9 lane order, R2 independence, R3 copy
        chk("R9", int'(buf_o[LANE_CODE_VIOL]), 1);
        chk("R9", int'(buf_o[LANE_PATTERN]), 5);
        chk_bufs("R3");
        do_tick('0);
        chk_bufs("R3");
        chk("R3", int'(buf_o[LANE_CRC6]), 0);
    endtask

    task automatic t_hold();
        pulse(5'b10101, 7);
        repeat (4) @(negedge clk);
        chk_bufs("R5");
        do_tick('0);
        chk_bufs("R2");
        chk("R2", int'(buf_o[LANE_FRAME_BIT]), 0);
    endtask

    task automatic t_req_in_auto();
        mode_auto = 1'b1;
        pulse(5'b00010, 3);
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        chk("R8", int'(busy), 0);
        @(negedge clk);
        chk("R8", int'(busy), 0);
        chk_bufs("R8");
        do_tick('0);
        chk("R8", int'(buf_o[LANE_FRAME_BIT]), 3);
    endtask

    task automatic t_on_demand();
        mode_auto = 1'b0;
        pulse(5'b11000, 9);
        do_tick('0);
        chk_bufs("R8");
        do_req('0, "R4");
        chk_bufs("R4");
        chk("R4", int'(buf_o[LANE_ERR_BLOCK]), 9);
    endtask

    task automatic t_coincident();
        mode_auto = 1'b0;
        pulse(5'b11111, 2);
        do_req(5'b11111, "R7");
        do_req('0, "R7");
        chk_bufs("R7");
        mode_auto = 1'b1;
        pulse(5'b00100, 4);
        do_tick(5'b00100);
        chk("R7", int'(buf_o[LANE_CRC6]), 4);
        do_tick('0);
        chk("R7", int'(buf_o[LANE_CRC6]), 1);
    endtask

    task automatic t_saturate();
        mode_auto = 1'b1;
        do_tick('0);
        pulse(5'b00001, 70000);
        do_tick('0);
        chk("R6", int'(buf_o[LANE_CODE_VIOL]), MAXV);
        chk_bufs("R6");
        do_tick('0);
        chk("R6", int'(buf_o[LANE_CODE_VIOL]), 0);
    endtask

    initial begin
        t_reset();
        t_auto_tick();
        t_hold();
        t_req_in_auto();
        t_on_demand();
        t_coincident();
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule